// File: doc/BRIEF.md
# Lockable GPIO Port with Per-Pin Function Selection

This block is an 8-bit general-purpose I/O port. Each pin can either act as plain GPIO or be handed to one of three peripheral functions. Plain GPIO is driven by a direction register and a data register. Software reaches the block over a small register bus made of write strobe, read strobe, address and data.

The function-select fields are guarded. A write to a select register is accepted only while a separate protection register holds the unlock key 0x96. This stops a stray store from re-routing pins. The protection register can always be written and always reads back its own value.

When a peripheral owns a pin, that peripheral's output value and output enable drive the pin, and the pin's GPIO direction bit has no effect. Data reads return the real pin level after a two-flop synchronizer, in input mode as well as in output mode.

Top module: `gpio_fnmux_port`

## Requirements
- R1: After reset the data, direction, both select registers and the protection register all read as zero, and every pin_oe bit is 0.
- R2: A pin whose select field is 0 drives pin_out from its data bit, and drives pin_oe from its direction bit (1 = output).
- R3: A pin in GPIO mode with direction 0 has pin_oe low. Writing its data bit does not change pin_oe. The written value appears on pin_out and is driven once the direction bit is set.
- R4: Reading address 0x0 returns pin_in through two clock registers. A level applied at a falling edge is returned after the second following rising edge, and not after the first.
- R5: A write to address 0x2 or 0x3 changes the select register only if the protection register holds 0x96 at that clock edge. Otherwise the write is dropped.
- R6: The protection register at address 0x4 accepts every write and reads back the written value. Any value other than 0x96, including 0x95, keeps the select registers locked.
- R7: Select value f (1, 2 or 3) on pin i routes alt_out[(f-1)*8+i] to pin_out[i] and alt_oe[(f-1)*8+i] to pin_oe[i]. The pin's direction bit is ignored.
- R8: Pin i's select field is at bits [2*(i%4)+1 : 2*(i%4)] of the select register at address 0x2 (pins 0-3) or 0x3 (pins 4-7).
- R9: Reads from addresses 0x5-0x7 return zero. bus_rdata is zero whenever bus_rd is low. A write to an unused address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address while bus_rd is high |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Value to drive on each pin |
| pin_oe | output | 8 | Per-pin driver enable |
| alt_out | input | 24 | Peripheral output values; bit (f-1)*8+i belongs to function f on pin i |
| alt_oe | input | 24 | Peripheral output enables, same layout as alt_out |

## Verification
Four behaviours are checked on every cycle:
- the select registers stay frozen while the key is absent;
- a write to the protection register lands exactly;
- the synchronized level lags pin_in by two clocks;
- a GPIO pin set as input never enables its driver.

Other behaviours need the bench's scenarios, which compare against a model of the register state:
- peripheral routing and the fact that the direction bit is ignored under a peripheral function;
- the field packing of the select registers;
- the near-miss key 0x95;
- zero reads from unused addresses.

// File: rtl/gpio_fnmux_pkg.sv
package gpio_fnmux_pkg;
   // width of one pin's function-select field
   localparam int FSEL_W       = 2;
   // peripheral functions selectable besides GPIO
   localparam int ALT_FUNCS    = 3;
   // select fields packed into one select register
   localparam int PINS_PER_SEL = 4;
   // fixed offsets of the register map
   localparam int DATA_OFS     = 0;
   localparam int DIR_OFS      = 1;
   localparam int SEL_BASE_OFS = 2;

   typedef enum logic [FSEL_W-1:0] {
      FN_GPIO  = 2'd0,
      FN_ALT_A = 2'd1,
      FN_ALT_B = 2'd2,
      FN_ALT_C = 2'd3
   } fn_sel_e;

   function automatic int sel_reg_count(input int pins);
      return (pins + PINS_PER_SEL - 1) / PINS_PER_SEL;
   endfunction
endpackage

// File: rtl/gpio_fnmux_sync.sv
module gpio_fnmux_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_fnmux_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] since_rst;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                since_rst <= '0;
            else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
         end
         // R4
         sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (dout == $past(din, 2)));
      end
   endgenerate
endmodule

// File: rtl/gpio_fnmux_regs.sv
module gpio_fnmux_regs
   import gpio_fnmux_pkg::*;
#(
   parameter int          PINS       = 8,
   parameter int          DW         = 8,
   parameter int          AW         = 3,
   parameter logic [DW-1:0] UNLOCK_KEY = 8'h96
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        wdata,
   input  logic [PINS-1:0]      pin_lvl,
   output logic [DW-1:0]        rdata,
   output logic [PINS-1:0]      data_q,
   output logic [PINS-1:0]      dir_q,
   output logic [PINS*FSEL_W-1:0] sel_q
);
   localparam int NSEL     = sel_reg_count(PINS);
   localparam int PROT_OFS = SEL_BASE_OFS + NSEL;

   generate
      if (PINS != DW) begin : g_bad_pins
         $error("gpio_fnmux_regs: PINS must equal DW");
      end
      if (PINS_PER_SEL * FSEL_W != DW) begin : g_bad_pack
         $error("gpio_fnmux_regs: one select register must fill DW bits");
      end
      if (PROT_OFS >= (1 << AW)) begin : g_bad_aw
         $error("gpio_fnmux_regs: AW too small for the register map");
      end
   endgenerate

   logic [DW-1:0] prot_q;
   logic          unlocked;

   assign unlocked = (prot_q == UNLOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         prot_q <= '0;
      end else if (wr_en) begin
         if (addr == AW'(DATA_OFS)) data_q <= wdata;
         if (addr == AW'(DIR_OFS))  dir_q  <= wdata;
         if (addr == AW'(PROT_OFS)) prot_q <= wdata;
      end
   end

   generate
      for (genvar r = 0; r < NSEL; r++) begin : g_selreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel_q[r*DW +: DW] <= '0;
            else if (wr_en && unlocked && addr == AW'(SEL_BASE_OFS + r))
               sel_q[r*DW +: DW] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == AW'(DATA_OFS)) rdata = pin_lvl;
         if (addr == AW'(DIR_OFS))  rdata = dir_q;
         if (addr == AW'(PROT_OFS)) rdata = prot_q;
         for (int r = 0; r < NSEL; r++) begin
            if (addr == AW'(SEL_BASE_OFS + r)) rdata = sel_q[r*DW +: DW];
         end
      end
   end

   // R5
   sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_q != UNLOCK_KEY) |=> $stable(sel_q));

   // R6
   prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(PROT_OFS)) |=> (prot_q == $past(wdata)));
endmodule

// File: rtl/gpio_fnmux_pinmux.sv
module gpio_fnmux_pinmux
   import gpio_fnmux_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic [PINS*FSEL_W-1:0]    sel,
   input  logic [PINS-1:0]           gpio_dat,
   input  logic [PINS-1:0]           gpio_dir,
   input  logic [ALT_FUNCS*PINS-1:0] alt_out,
   input  logic [ALT_FUNCS*PINS-1:0] alt_oe,
   output logic [PINS-1:0]           pin_out,
   output logic [PINS-1:0]           pin_oe
);
   generate
      for (genvar i = 0; i < PINS; i++) begin : g_pin
         fn_sel_e fn;
         assign fn = fn_sel_e'(sel[i*FSEL_W +: FSEL_W]);
         always_comb begin
            unique case (fn)
               FN_ALT_A: begin
                  pin_out[i] = alt_out[0*PINS + i];
                  pin_oe[i]  = alt_oe[0*PINS + i];
               end
               FN_ALT_B: begin
                  pin_out[i] = alt_out[1*PINS + i];
                  pin_oe[i]  = alt_oe[1*PINS + i];
               end
               FN_ALT_C: begin
                  pin_out[i] = alt_out[2*PINS + i];
                  pin_oe[i]  = alt_oe[2*PINS + i];
               end
               default: begin
                  pin_out[i] = gpio_dat[i];
                  pin_oe[i]  = gpio_dir[i];
               end
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_fnmux_port.sv
module gpio_fnmux_port
   import gpio_fnmux_pkg::*;
#(
   parameter int            PINS        = 8,
   parameter int            DW          = 8,
   parameter int            AW          = 3,
   parameter logic [DW-1:0] UNLOCK_KEY  = 8'h96,
   parameter int            SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_rd,
   input  logic [AW-1:0]              bus_addr,
   input  logic [DW-1:0]              bus_wdata,
   output logic [DW-1:0]              bus_rdata,
   input  logic [PINS-1:0]            pin_in,
   output logic [PINS-1:0]            pin_out,
   output logic [PINS-1:0]            pin_oe,
   input  logic [ALT_FUNCS*PINS-1:0]  alt_out,
   input  logic [ALT_FUNCS*PINS-1:0]  alt_oe
);
   logic [PINS-1:0]        pin_lvl;
   logic [PINS-1:0]        data_q;
   logic [PINS-1:0]        dir_q;
   logic [PINS*FSEL_W-1:0] sel_q;

   gpio_fnmux_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pin_lvl)
   );

   gpio_fnmux_regs #(.PINS(PINS), .DW(DW), .AW(AW), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr),
      .rd_en  (bus_rd),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .pin_lvl(pin_lvl),
      .rdata  (bus_rdata),
      .data_q (data_q),
      .dir_q  (dir_q),
      .sel_q  (sel_q)
   );

   gpio_fnmux_pinmux #(.PINS(PINS)) u_pinmux (
      .sel     (sel_q),
      .gpio_dat(data_q),
      .gpio_dir(dir_q),
      .alt_out (alt_out),
      .alt_oe  (alt_oe),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   generate
      for (genvar i = 0; i < PINS; i++) begin : g_oe_chk
         // R3
         input_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[i*FSEL_W +: FSEL_W] == '0 && !dir_q[i]) |-> !pin_oe[i]);
      end
   endgenerate
endmodule

// File: tb/gpio_fnmux_port_bench.sv
module gpio_fnmux_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;
   logic [23:0] alt_out = '0;
   logic [23:0] alt_oe = '0;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   // model of the register state
   logic [7:0]  m_data, m_dir, m_prot, m_pins;
   logic [15:0] m_sel;

   always #4 clk = ~clk;

   gpio_fnmux_port u_gpio_fnmux_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .alt_out(alt_out), .alt_oe(alt_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_out();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin
         int f = int'(m_sel[2*i +: 2]);
         v[i] = (f == 0) ? m_data[i] : alt_out[(f-1)*8 + i];
      end
      return v;
   endfunction

   function automatic logic [7:0] exp_oe();
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin
         int f = int'(m_sel[2*i +: 2]);
         v[i] = (f == 0) ? m_dir[i] : alt_oe[(f-1)*8 + i];
      end
      return v;
   endfunction

   function automatic logic [7:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0: return m_pins;
         3'd1: return m_dir;
         3'd2: return m_sel[7:0];
         3'd3: return m_sel[15:8];
         3'd4: return m_prot;
         default: return 8'h00;
      endcase
   endfunction

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         3'd0: m_data = d;
         3'd1: m_dir = d;
         3'd2: if (m_prot == 8'h96) m_sel[7:0] = d;
         3'd3: if (m_prot == 8'h96) m_sel[15:8] = d;
         3'd4: m_prot = d;
         default: ;
      endcase
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (2) @(posedge clk);
      m_pins = v;
   endtask

   task automatic check_pins(input string req);
      check({req, " pin_out"}, pin_out, exp_out());
      check({req, " pin_oe"}, pin_oe, exp_oe());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20240611));
      m_data = '0; m_dir = '0; m_prot = '0; m_pins = '0; m_sel = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd1, d); check("R1 dir", d, 8'h00);
      rd(3'd2, d); check("R1 sel lo", d, 8'h00);
      rd(3'd3, d); check("R1 sel hi", d, 8'h00);
      rd(3'd4, d); check("R1 prot", d, 8'h00);
      check("R1 pin_oe", pin_oe, 8'h00);

      // R3 data write while input, then R2 output mode
      wr(3'd0, 8'hA5);
      check("R3 oe stays low", pin_oe, 8'h00);
      check("R3 data on pin_out", pin_out, 8'hA5);
      wr(3'd1, 8'h0F);
      check("R2 pin_oe", pin_oe, 8'h0F);
      check("R2 pin_out", pin_out, 8'hA5);

      // R4 synchronizer latency
      set_pins(8'h3C);
      rd(3'd0, d); check("R4 settled", d, 8'h3C);
      @(negedge clk); pin_in = 8'hC3;
      @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd0; #1 d = bus_rdata; bus_rd = 1'b0;
      check("R4 one edge old", d, 8'h3C);
      @(negedge clk); bus_rd = 1'b1; #1 d = bus_rdata; bus_rd = 1'b0;
      check("R4 two edges new", d, 8'hC3);
      m_pins = 8'hC3;

      // R5 locked write dropped, R6 near-miss key
      wr(3'd2, 8'hE4);
      rd(3'd2, d); check("R5 locked", d, 8'h00);
      wr(3'd4, 8'h95);
      rd(3'd4, d); check("R6 prot readback", d, 8'h95);
      wr(3'd3, 8'hFF);
      rd(3'd3, d); check("R6 0x95 still locked", d, 8'h00);

      // R8 packing after unlock
      wr(3'd4, 8'h96);
      wr(3'd2, 8'hE4);
      wr(3'd3, 8'h1B);
      rd(3'd2, d); check("R8 sel lo", d, 8'hE4);
      rd(3'd3, d); check("R8 sel hi", d, 8'h1B);
      wr(3'd4, 8'h00);
      wr(3'd2, 8'h00);
      rd(3'd2, d); check("R5 relocked", d, 8'hE4);

      // R7 peripheral routing, direction ignored
      @(negedge clk);
      alt_out = 24'hF0_5A_C3; alt_oe = 24'h0F_A5_3C;
      #1 check_pins("R7 alt");
      wr(3'd1, 8'h00);
      check_pins("R7 dir ignored");
      wr(3'd1, 8'hFF);
      check_pins("R7 dir ignored hi");

      // R9 unused addresses and idle read data
      rd(3'd5, d); check("R9 addr5", d, 8'h00);
      rd(3'd7, d); check("R9 addr7", d, 8'h00);
      @(negedge clk); bus_addr = 3'd1; #1 check("R9 rd low", bus_rdata, 8'h00);

      // random mix against the model
      for (int n = 0; n < 600; n++) begin
         logic [2:0] a = 3'($urandom_range(0, 7));
         logic [7:0] v = 8'($urandom);
         if ($urandom_range(0, 5) == 0) begin a = 3'd4; v = 8'h96; end
         case ($urandom_range(0, 3))
            0: set_pins(8'($urandom));
            1: begin
               @(negedge clk);
               alt_out = 24'($urandom); alt_oe = 24'($urandom);
               #1 check_pins("R7 random alt");
            end
            default: begin
               wr(a, v);
               check_pins("R2 random");
            end
         endcase
         a = 3'($urandom_range(0, 7));
         rd(a, d);
         check($sformatf("R5 random read addr %0d", a), d, exp_read(a));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule